// File: doc/BRIEF.md
# AGP Arbiter Status Sequencer

This block sits on the bridge side of an AGP port and decides, transfer by transfer, what the granted master does next. A command queue reports how many transfers of each kind are pending: high-priority read returns, high-priority write-data requests, low-priority read returns, low-priority write-data requests and fast writes. The master also has a pending request for a new bus transaction. The block picks one action, drives grant together with a 3-bit status code, and holds both steady for a fixed window of clocks. It then drops grant for at least one clock before it decides again.

Two flow-control inputs from the master are examined only in the decision cycle, before a window opens. Read-buffer-full holds back low-priority read returns. Write-buffer-full holds back fast-write data. A mode input selects the later signaling semantics. In that mode the high-priority codes are reserved, so high-priority work is left queued. Each chosen queued transfer is reported back to the queue with a one-cycle take pulse, so that the queue can retire the entry.

Top module: `agp_status_seq`

## Requirements
- R1: In reset and in the first cycle after reset, grant is low, the fast-write window is low, every take bit is low and the status code is 3'b111.
- R2: A granted window carries status 3'b001 for a high-priority read return, 3'b011 for high-priority write data, 3'b000 for a low-priority read return, 3'b010 for low-priority write data, and 3'b111 for permission to start a new transaction.
- R3: When several actions are eligible, the order of choice is high-priority read, high-priority write, low-priority read, low-priority write, fast write, and then a new transaction.
- R4: Each window keeps grant (or the fast-write window) high for exactly HOLD_CLKS clocks with the status stable, and is followed by at least one clock with both low.
- R5: In the first clock of a window, take carries exactly one set bit for the class served (bit 0 high-priority read, 1 high-priority write, 2 low-priority read, 3 low-priority write, 4 fast write). A new-transaction window sets no take bit.
- R6: With mode3 high, high-priority classes are never served, and status codes 3'b001 and 3'b011 are never emitted.
- R7: Read-buffer-full high in the decision cycle prevents a low-priority read return; lower classes may still be served.
- R8: Write-buffer-full high in the decision cycle prevents a fast write.
- R9: A change on either buffer-full input during an open window does not alter grant, status or the window length.
- R10: Codes 3'b100, 3'b101 and 3'b110 are never emitted, and while grant is low the status reads 3'b111.
- R11: A fast write raises fw_drive for the window and keeps grant low throughout.
- R12: A class with a zero count is never served. With nothing pending and no new request, grant and fw_drive stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode3 | input | 1 | 1 selects the later signaling semantics |
| req_new | input | 1 | Master requests a new transaction |
| rbf | input | 1 | Master read buffer full |
| wbf | input | 1 | Master write buffer full |
| hprd_cnt | input | CW | Pending high-priority read returns |
| hpwr_cnt | input | CW | Pending high-priority write-data requests |
| lprd_cnt | input | CW | Pending low-priority read returns |
| lpwr_cnt | input | CW | Pending low-priority write-data requests |
| fw_cnt | input | CW | Pending fast writes |
| gnt | output | 1 | Grant; status is meaningful only while high |
| status | output | 3 | Action code for the granted master |
| fw_drive | output | 1 | Fast-write data window |
| take | output | 5 | One-cycle retire pulse per served class |

## Verification
The assertions assume that mode3 stays constant while a window is open. They also assume that the queue lowers a count only in response to a take pulse, within the following window. The stimulus changes mode3 and the counts only while grant and fw_drive are low, with one exception: a queue model lowers a count by one at the falling clock edge after each take. The buffer-full inputs may change at any time. The bench deliberately toggles them in the middle of a window, to show that they are examined only in the decision cycle.

// File: rtl/agp_seq_pkg.sv
package agp_seq_pkg;
  localparam int NCLS = 6;
  localparam int NQ   = 5;

  // class index order is the priority order, lowest index wins
  localparam int CL_HPRD = 0;
  localparam int CL_HPWR = 1;
  localparam int CL_LPRD = 2;
  localparam int CL_LPWR = 3;
  localparam int CL_FW   = 4;
  localparam int CL_NEW  = 5;

  localparam logic [2:0] ST_LPRD = 3'b000;
  localparam logic [2:0] ST_HPRD = 3'b001;
  localparam logic [2:0] ST_LPWR = 3'b010;
  localparam logic [2:0] ST_HPWR = 3'b011;
  localparam logic [2:0] ST_PARK = 3'b111;

  function automatic logic [2:0] status_of(input int idx);
    case (idx)
      CL_HPRD: status_of = ST_HPRD;
      CL_HPWR: status_of = ST_HPWR;
      CL_LPRD: status_of = ST_LPRD;
      CL_LPWR: status_of = ST_LPWR;
      default: status_of = ST_PARK;
    endcase
  endfunction

  function automatic logic [2:0] code_from_pick(input logic [NCLS-1:0] oh);
    logic [2:0] c;
    c = ST_PARK;
    for (int i = 0; i < NCLS; i++)
      if (oh[i]) c = status_of(i);
    return c;
  endfunction
endpackage

// File: rtl/agp_seq_elig.sv
module agp_seq_elig
  import agp_seq_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [NQ-1:0][CW-1:0] cnt,
  input  logic                  req_new,
  input  logic                  mode3,
  input  logic                  rbf,
  input  logic                  wbf,
  output logic [NCLS-1:0]       elig
);
  logic [NQ-1:0] nz;
  logic [NQ-1:0] allow;

  always_comb begin
    allow          = '1;
    allow[CL_HPRD] = !mode3;
    allow[CL_HPWR] = !mode3;
    allow[CL_LPRD] = !rbf;
    allow[CL_FW]   = !wbf;
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign nz[g]   = |cnt[g];
    assign elig[g] = nz[g] & allow[g];
  end
  assign elig[CL_NEW] = req_new;
endmodule

// File: rtl/agp_seq_pick.sv
module agp_seq_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] oh
);
  logic [N:0] above;
  assign above[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_p
    assign oh[g]      = req[g] & ~above[g];
    assign above[g+1] = above[g] | req[g];
  end
endmodule

// File: rtl/agp_seq_timer.sv
module agp_seq_timer #(
  parameter int HOLD = 4,
  localparam int TW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= TW'(HOLD - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign last = busy && (cnt == '0);
endmodule

// File: rtl/agp_status_seq.sv
module agp_status_seq
  import agp_seq_pkg::*;
#(
  parameter int QDEPTH    = 32,
  parameter int HOLD_CLKS = 4,
  localparam int CW       = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode3,
  input  logic          req_new,
  input  logic          rbf,
  input  logic          wbf,
  input  logic [CW-1:0] hprd_cnt,
  input  logic [CW-1:0] hpwr_cnt,
  input  logic [CW-1:0] lprd_cnt,
  input  logic [CW-1:0] lpwr_cnt,
  input  logic [CW-1:0] fw_cnt,
  output logic          gnt,
  output logic [2:0]    status,
  output logic          fw_drive,
  output logic [4:0]    take
);
  logic [NQ-1:0][CW-1:0] cnt_v;
  logic [NCLS-1:0]       elig;
  logic [NCLS-1:0]       pick;
  logic                  busy;
  logic                  last;
  logic                  decide_w;
  logic                  start_w;

  assign cnt_v[CL_HPRD] = hprd_cnt;
  assign cnt_v[CL_HPWR] = hpwr_cnt;
  assign cnt_v[CL_LPRD] = lprd_cnt;
  assign cnt_v[CL_LPWR] = lpwr_cnt;
  assign cnt_v[CL_FW]   = fw_cnt;

  agp_seq_elig #(.CW(CW)) u_elig (
    .cnt(cnt_v), .req_new(req_new), .mode3(mode3),
    .rbf(rbf), .wbf(wbf), .elig(elig)
  );

  agp_seq_pick #(.N(NCLS)) u_pick (.req(elig), .oh(pick));

  // flow-control inputs matter only here, in the cycle before a window opens
  assign decide_w = !busy;
  assign start_w  = decide_w && (|pick);

  agp_seq_timer #(.HOLD(HOLD_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(start_w), .busy(busy), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= 1'b0;
      fw_drive <= 1'b0;
      status   <= ST_PARK;
      take     <= '0;
    end else begin
      take <= start_w ? pick[NQ-1:0] : '0;
      if (start_w) begin
        if (pick[CL_FW]) begin
          fw_drive <= 1'b1;
          status   <= ST_PARK;
        end else begin
          gnt      <= 1'b1;
          status   <= code_from_pick(pick);
        end
      end else if (last) begin
        gnt      <= 1'b0;
        fw_drive <= 1'b0;
        status   <= ST_PARK;
      end
    end
  end
endmodule

// File: rtl/agp_seq_chk.sv
module agp_seq_chk #(
  parameter int HOLD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode3,
  input logic       rbf,
  input logic       wbf,
  input logic       gnt,
  input logic [2:0] status,
  input logic       fw_drive,
  input logic [4:0] take
);
  int unsigned grun, frun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grun <= 0;
      frun <= 0;
    end else begin
      grun <= gnt ? grun + 1 : 0;
      frun <= fw_drive ? frun + 1 : 0;
    end
  end

  a_r4_gnt_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt && $past(gnt)) |-> (grun == HOLD));
  a_r4_fw_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_drive && $past(fw_drive)) |-> (frun == HOLD));
  a_r4_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && $past(gnt)) |-> $stable(status));
  a_r10_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !(status inside {3'b100, 3'b101, 3'b110}));
  a_r10_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt |-> (status == 3'b111));
  a_r5_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  a_r5_take_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (|take[3:0]) |-> $rose(gnt));
  a_r6_no_hp_mode3: assert property (@(posedge clk) disable iff (!rst_n)
    (take[0] || take[1]) |-> !$past(mode3));
  a_r7_rbf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take[2] |-> !$past(rbf));
  a_r8_wbf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take[4] |-> (!$past(wbf) && $rose(fw_drive)));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt && fw_drive));
endmodule

bind agp_status_seq agp_seq_chk #(.HOLD(HOLD_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode3(mode3), .rbf(rbf), .wbf(wbf),
  .gnt(gnt), .status(status), .fw_drive(fw_drive), .take(take)
);

// File: tb/agp_status_seq_tb.sv
module agp_status_seq_tb;
  localparam int HOLD = 4;
  localparam int CW   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode3 = 0, req_new = 0, rbf = 0, wbf = 0;
  logic [CW-1:0] hprd_cnt = 0, hpwr_cnt = 0, lprd_cnt = 0, lpwr_cnt = 0, fw_cnt = 0;
  logic gnt, fw_drive;
  logic [2:0] status;
  logic [4:0] take;

  int checks = 0, errors = 0;
  int lg[64];
  int nlog = 0;
  logic pg = 0, pf = 0;
  int bad_res = 0, bad_park = 0, bad_both = 0;

  always #2 clk = ~clk;

  agp_status_seq #(.QDEPTH(32), .HOLD_CLKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode3(mode3), .req_new(req_new),
    .rbf(rbf), .wbf(wbf), .hprd_cnt(hprd_cnt), .hpwr_cnt(hpwr_cnt),
    .lprd_cnt(lprd_cnt), .lpwr_cnt(lpwr_cnt), .fw_cnt(fw_cnt),
    .gnt(gnt), .status(status), .fw_drive(fw_drive), .take(take)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and queue model: log window starts (status code, 8 for fast write)
  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt && !pg && nlog < 64) begin lg[nlog] = int'(status); nlog++; end
      if (fw_drive && !pf && nlog < 64) begin lg[nlog] = 8; nlog++; end
      if (status inside {3'b100, 3'b101, 3'b110}) bad_res++;
      if (!gnt && status != 3'b111) bad_park++;
      if (gnt && fw_drive) bad_both++;
      if (take[0]) hprd_cnt = hprd_cnt - 1;
      if (take[1]) hpwr_cnt = hpwr_cnt - 1;
      if (take[2]) lprd_cnt = lprd_cnt - 1;
      if (take[3]) lpwr_cnt = lpwr_cnt - 1;
      if (take[4]) fw_cnt   = fw_cnt - 1;
      pg = gnt;
      pf = fw_drive;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 200 && nlog < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 gnt", gnt, 0);
    chk("R1 fw_drive", fw_drive, 0);
    chk("R1 take", take, 0);
    chk("R1 status", status, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gnt after release", gnt, 0);
    chk("R1 status after release", status, 7);
  endtask

  task automatic t_priority;
    int exp[6] = '{1, 3, 0, 2, 8, 7};
    int base;
    cyc(1);
    base = nlog;
    hprd_cnt = 1; hpwr_cnt = 1; lprd_cnt = 1; lpwr_cnt = 1; fw_cnt = 1;
    req_new = 1;
    wait_log(base + 6);
    req_new = 0;
    for (int i = 0; i < 6; i++) chk($sformatf("R3 R2 order slot %0d", i), lg[base + i], exp[i]);
    cyc(12);
    chk("R5 queue drained", int'(hprd_cnt + hpwr_cnt + lprd_cnt + lpwr_cnt + fw_cnt), 0);
  endtask

  task automatic t_hold;
    int len = 0;
    logic stable = 1;
    logic [2:0] s0;
    logic [4:0] t0;
    lpwr_cnt = 1;
    while (!gnt) @(negedge clk);
    s0 = status;
    t0 = take;
    while (gnt) begin
      if (status != s0) stable = 0;
      len++;
      @(negedge clk);
      if (len == 1 && take != 0) stable = 0;
    end
    chk("R4 window length", len, HOLD);
    chk("R4 status stable", stable, 1);
    chk("R5 take bit low-priority write", t0, 5'b01000);
    chk("R4 gap after window", gnt | fw_drive, 0);
    chk("R2 low-priority write code", s0, 2);
  endtask

  task automatic t_mode3;
    int base;
    cyc(2);
    mode3 = 1;
    base = nlog;
    hprd_cnt = 2; hpwr_cnt = 2;
    cyc(40);
    chk("R6 no high-priority service", nlog - base, 0);
    chk("R6 counts untouched", int'(hprd_cnt + hpwr_cnt), 4);
    lprd_cnt = 1;
    wait_log(base + 1);
    chk("R6 low-priority read in mode3", lg[base], 0);
    cyc(8);
    hprd_cnt = 0; hpwr_cnt = 0;
    mode3 = 0;
  endtask

  task automatic t_rbf;
    int base;
    cyc(2);
    base = nlog;
    rbf = 1;
    lprd_cnt = 1; lpwr_cnt = 1;
    wait_log(base + 1);
    chk("R7 lower class passes blocked read", lg[base], 2);
    cyc(30);
    chk("R7 read held while full", nlog - base, 1);
    rbf = 0;
    wait_log(base + 2);
    chk("R7 read after release", lg[base + 1], 0);
    cyc(8);
  endtask

  task automatic t_midwin;
    int len = 0;
    logic stable = 1;
    lprd_cnt = 1;
    while (!gnt) @(negedge clk);
    rbf = 1; wbf = 1;
    while (gnt) begin
      if (status != 3'b000) stable = 0;
      len++;
      @(negedge clk);
    end
    chk("R9 window length with rbf raised", len, HOLD);
    chk("R9 status unchanged", stable, 1);
    rbf = 0; wbf = 0;
    cyc(4);
  endtask

  task automatic t_wbf;
    int base, len = 0;
    logic glow = 1;
    cyc(2);
    base = nlog;
    wbf = 1;
    fw_cnt = 1;
    cyc(30);
    chk("R8 no fast write while full", nlog - base, 0);
    chk("R8 count kept", fw_cnt, 1);
    wbf = 0;
    while (!fw_drive) @(negedge clk);
    while (fw_drive) begin
      if (gnt) glow = 0;
      len++;
      @(negedge clk);
    end
    chk("R11 fast write window length", len, HOLD);
    chk("R11 grant low during fast write", glow, 1);
    chk("R8 served after release", lg[base], 8);
  endtask

  task automatic t_empty;
    int base;
    cyc(4);
    base = nlog;
    cyc(30);
    chk("R12 idle without work", nlog - base, 0);
    chk("R12 grant low", gnt | fw_drive, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_priority();
    t_hold();
    t_mode3();
    t_rbf();
    t_midwin();
    t_wbf();
    t_empty();
    chk("R10 reserved codes", bad_res, 0);
    chk("R10 parked code while idle", bad_park, 0);
    chk("R11 grant and fast write overlap", bad_both, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule